// File: doc/BRIEF.md
# Live State Migration Controller

This block moves the contents of a small bank of clock-enabled registers from the copy that currently drives the system (the original) to a spare copy (the replica). The user circuit keeps running the whole time. The migration has two phases. In the first phase the replica is configured, its inputs are paralleled with the original's, and the stored state is copied across. In the second phase the replica's outputs are connected to the system and the original is released.

User writes, qualified by a per-register clock enable, may arrive in any cycle of the migration. The controller never forces the enable. Instead it copies the original's outputs into the replica on one dedicated transfer cycle. From that cycle on, every user write lands in both copies, so no update is lost. A comparator confirms that the two banks are equal before the outputs are switched; on a mismatch the transfer is repeated. Configuration-memory access and routing lie outside the block. Each is represented by one request/acknowledge pair: one for setting up the replica, one for connecting its outputs.

When the function holds no state, a combinational-only mode skips the copy and the compare, and simply switches.

Top module: `state_migrate_ctrl`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, both banks read zero, and `outSel`, `done`, `cfgReq` and `linkReq` are 0.
- R2: A `startReq` sampled while idle raises `cfgReq` at the next edge. `cfgReq` stays high, and the sequence does not advance, until `cfgAck` is sampled high.
- R3: Before the transfer cycle (idle and configuration wait), a user write updates only the original; `replQ` keeps its previous value.
- R4: On the transfer cycle, each replica register loads the original's current value. If that register's `userWe` bit is 1 in the same cycle, the user data is written to both copies instead.
- R5: From the cycle after the transfer until the original is released, a user write updates both copies.
- R6: After a transfer, unequal banks cause the transfer to run again, which adds two cycles. `replDisturb` = 1 flips bit 0 of replica register 0 at that edge, to model an upset.
- R7: After the banks compare equal, there is one full parallel cycle before `linkReq` rises.
- R8: `outSel` rises only at the edge where `linkAck` is sampled high while `linkReq` is 1. `sysOut` equals `origQ` while `outSel` is 0, and `replQ` while it is 1.
- R9: From the cycle in which `outSel` is 1, user writes no longer change `origQ`, and they still update `replQ`.
- R10: `done` rises one cycle after `outSel` rises and stays high until reset; further `startReq` pulses have no effect. With acknowledges already high, `done` is seen 7 edges after the start edge.
- R11: With `combOnly` = 1, the transfer and compare are skipped and the replica is not loaded from the original. With acknowledges already high, `done` is seen 5 edges after the start edge.

Register i of a bank occupies bits [i*DATA_W +: DATA_W] of `userData`, `origQ`, `replQ` and `sysOut`. Bit i of `userWe` enables register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to begin a migration |
| combOnly | input | 1 | Function holds no state: skip the transfer |
| userWe | input | NUM_REGS | Per-register user clock enable |
| userData | input | NUM_REGS*DATA_W | User write data |
| replDisturb | input | 1 | Upset model: flip bit 0 of replica register 0 |
| cfgReq | output | 1 | Replica configuration request |
| cfgAck | input | 1 | Replica configuration complete |
| linkReq | output | 1 | Request to connect the replica outputs |
| linkAck | input | 1 | Replica outputs connected |
| origQ | output | NUM_REGS*DATA_W | Original bank contents |
| replQ | output | NUM_REGS*DATA_W | Replica bank contents |
| sysOut | output | NUM_REGS*DATA_W | Value seen by the system |
| outSel | output | 1 | Output mux select (1 = replica) |
| done | output | 1 | Migration finished |

## Verification
The bench places a user write at every stage of the sequence and checks where it ends up:
- A write in the same cycle as the transfer checks that user data wins. A design without that priority would end with the old value in the replica.
- A write one cycle after release checks that the original is frozen while the replica still takes writes.

An injected replica upset checks that the comparator gates the switch. A design without it would connect a corrupted replica, or finish two cycles early. Withheld acknowledges check that a design does not run ahead of configuration, or move the output mux before the link exists.

// File: rtl/mig_pkg.sv
package mig_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG,
    ST_XFER,
    ST_CHECK,
    ST_PAR,
    ST_LINK,
    ST_REL,
    ST_FIN
  } migState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadXfer;   // dedicated transfer cycle
    logic replTrack;  // replica inputs paralleled with original
    logic origLive;   // original still accepts user writes
    logic selRepl;    // system reads the replica
  } migStrobe_t;

endpackage

// File: rtl/mig_datapath.sv
module mig_datapath
  import mig_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  migStrobe_t                   strobe,
  input  logic [NUM_REGS-1:0]          userWe,
  input  logic [NUM_REGS*DATA_W-1:0]   userData,
  input  logic                         replDisturb,
  output logic [NUM_REGS*DATA_W-1:0]   origFlat,
  output logic [NUM_REGS*DATA_W-1:0]   replFlat,
  output logic [NUM_REGS*DATA_W-1:0]   muxOut,
  output logic                         banksEqual
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] origReg;
    logic [DATA_W-1:0] replReg;
    logic [DATA_W-1:0] replNext;
    logic [DATA_W-1:0] wrData;

    assign wrData = userData[i*DATA_W +: DATA_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        origReg <= '0;
      end else if (strobe.origLive && userWe[i]) begin
        origReg <= wrData;
      end
    end

    always_comb begin
      if (strobe.loadXfer) begin
        replNext = userWe[i] ? wrData : origReg;
      end else if (strobe.replTrack && userWe[i]) begin
        replNext = wrData;
      end else begin
        replNext = replReg;
      end
    end

    if (i == 0) begin : g_upset
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          replReg <= '0;
        end else begin
          replReg <= replNext ^ {{(DATA_W-1){1'b0}}, replDisturb};
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          replReg <= '0;
        end else begin
          replReg <= replNext;
        end
      end
    end

    assign origFlat[i*DATA_W +: DATA_W] = origReg;
    assign replFlat[i*DATA_W +: DATA_W] = replReg;
  end

  assign banksEqual = (origFlat == replFlat);
  assign muxOut     = strobe.selRepl ? replFlat : origFlat;

endmodule

// File: rtl/mig_control.sv
module mig_control
  import mig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       combOnly,
  input  logic       cfgAck,
  input  logic       linkAck,
  input  logic       banksEqual,
  output migStrobe_t strobe,
  output logic       cfgReq,
  output logic       linkReq,
  output logic       done
);

  migState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (startReq) stateNext = ST_CFG;
      ST_CFG:   if (cfgAck)   stateNext = combOnly ? ST_PAR : ST_XFER;
      ST_XFER:  stateNext = ST_CHECK;
      ST_CHECK: stateNext = banksEqual ? ST_PAR : ST_XFER;
      ST_PAR:   stateNext = ST_LINK;
      ST_LINK:  if (linkAck)  stateNext = ST_REL;
      ST_REL:   stateNext = ST_FIN;
      ST_FIN:   stateNext = ST_FIN;
      default:  stateNext = ST_IDLE;
    endcase
  end

  // All outputs decode the registered state, so they move only on an edge
  always_comb begin
    strobe.loadXfer  = (state == ST_XFER);
    strobe.replTrack = (state == ST_CHECK) || (state == ST_PAR) ||
                       (state == ST_LINK)  || (state == ST_REL) ||
                       (state == ST_FIN);
    strobe.origLive  = (state != ST_REL) && (state != ST_FIN);
    strobe.selRepl   = (state == ST_REL) || (state == ST_FIN);
  end

  assign cfgReq  = (state == ST_CFG);
  assign linkReq = (state == ST_LINK);
  assign done    = (state == ST_FIN);

endmodule

// File: rtl/state_migrate_ctrl.sv
module state_migrate_ctrl
  import mig_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startReq,
  input  logic                         combOnly,
  input  logic [NUM_REGS-1:0]          userWe,
  input  logic [NUM_REGS*DATA_W-1:0]   userData,
  input  logic                         replDisturb,
  output logic                         cfgReq,
  input  logic                         cfgAck,
  output logic                         linkReq,
  input  logic                         linkAck,
  output logic [NUM_REGS*DATA_W-1:0]   origQ,
  output logic [NUM_REGS*DATA_W-1:0]   replQ,
  output logic [NUM_REGS*DATA_W-1:0]   sysOut,
  output logic                         outSel,
  output logic                         done
);

  localparam int TOTAL_W = NUM_REGS * DATA_W;

  migStrobe_t strobe;
  logic       banksEqual;

  mig_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .combOnly   (combOnly),
    .cfgAck     (cfgAck),
    .linkAck    (linkAck),
    .banksEqual (banksEqual),
    .strobe     (strobe),
    .cfgReq     (cfgReq),
    .linkReq    (linkReq),
    .done       (done)
  );

  mig_datapath #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .userWe      (userWe),
    .userData    (userData),
    .replDisturb (replDisturb),
    .origFlat    (origQ),
    .replFlat    (replQ),
    .muxOut      (sysOut),
    .banksEqual  (banksEqual)
  );

  assign outSel = strobe.selRepl;

endmodule

// File: rtl/mig_checker.sv
module mig_checker #(
  parameter int TOTAL_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgReq,
  input logic               cfgAck,
  input logic               linkReq,
  input logic               linkAck,
  input logic [TOTAL_W-1:0] origQ,
  input logic               outSel,
  input logic               done
);

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && !cfgAck) |=> cfgReq);

  // R7
  par_before_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkReq) |-> $past(!cfgReq && !linkReq));

  // R8
  sel_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outSel) |-> $past(linkReq && linkAck));

  // R9
  orig_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(outSel) |-> $stable(origQ));

  // R10
  done_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (outSel && $past(outSel)));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

endmodule

bind state_migrate_ctrl mig_checker #(.TOTAL_W(TOTAL_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgReq  (cfgReq),
  .cfgAck  (cfgAck),
  .linkReq (linkReq),
  .linkAck (linkAck),
  .origQ   (origQ),
  .outSel  (outSel),
  .done    (done)
);

// File: tb/state_migrate_ctrl_bench.sv
`timescale 1ns/1ps
module state_migrate_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        combOnly = 1'b0;
  logic [3:0]  userWe = '0;
  logic [31:0] userData = '0;
  logic        replDisturb = 1'b0;
  logic        cfgReq, linkReq, outSel, done;
  logic        cfgAck = 1'b0;
  logic        linkAck = 1'b0;
  logic [31:0] origQ, replQ, sysOut;

  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk;

  state_migrate_ctrl u_state_migrate_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .combOnly(combOnly),
    .userWe(userWe), .userData(userData), .replDisturb(replDisturb),
    .cfgReq(cfgReq), .cfgAck(cfgAck), .linkReq(linkReq), .linkAck(linkAck),
    .origQ(origQ), .replQ(replQ), .sysOut(sysOut), .outSel(outSel), .done(done)
  );

  typedef struct packed {
    logic [31:0] pre;
    logic [3:0]  we;
    logic [31:0] wd;
    logic [3:0]  wEdge;  // 15 = no write
    logic [3:0]  dEdge;  // 15 = no upset
    logic        comb;
    logic [3:0]  cyc;
    logic [31:0] expR;
    logic [31:0] expO;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h11223344, 4'b0000, 32'h0,        4'd15, 4'd15, 1'b0, 4'd7, 32'h11223344, 32'h11223344},
    '{32'hA5A50F0F, 4'b1111, 32'hDEADBEEF, 4'd2,  4'd15, 1'b0, 4'd7, 32'hDEADBEEF, 32'hDEADBEEF},
    '{32'h01020304, 4'b0010, 32'h00007700, 4'd0,  4'd15, 1'b0, 4'd7, 32'h01027704, 32'h01027704},
    '{32'hCAFEF00D, 4'b1000, 32'h5A000000, 4'd3,  4'd15, 1'b0, 4'd7, 32'h5AFEF00D, 32'h5AFEF00D},
    '{32'h12345678, 4'b0001, 32'h000000FF, 4'd6,  4'd15, 1'b0, 4'd7, 32'h123456FF, 32'h12345678},
    '{32'h87654321, 4'b0000, 32'h0,        4'd15, 4'd2,  1'b0, 4'd9, 32'h87654321, 32'h87654321},
    '{32'h0F0F0F0F, 4'b0000, 32'h0,        4'd15, 4'd15, 1'b1, 4'd5, 32'h00000000, 32'h0F0F0F0F},
    '{32'h33333333, 4'b0100, 32'h00990000, 4'd5,  4'd15, 1'b0, 4'd7, 32'h33993333, 32'h33993333}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; startReq = 0; userWe = '0; replDisturb = 0;
    cfgAck = 0; linkAck = 0; combOnly = 0;
    repeat (3) tick();
    rstN = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    chk("R1 outSel", {31'b0, outSel}, 32'h0);
    chk("R1 done", {31'b0, done}, 32'h0);
    chk("R1 reqs", {30'b0, cfgReq, linkReq}, 32'h0);
    chk("R1 origQ", origQ, 32'h0);
    chk("R1 replQ", replQ, 32'h0);

    // Table: one migration per vector, acknowledges always high
    for (int v = 0; v < NVEC; v++) begin
      int cycles;
      doReset();
      userWe = 4'hF; userData = VECS[v].pre; tick(); userWe = '0;
      chk("R8 sysOut before switch", sysOut, VECS[v].pre);
      combOnly = VECS[v].comb; cfgAck = 1; linkAck = 1;
      cycles = 0;
      for (int e = 0; e < 15; e++) begin
        startReq    = (e == 0);
        userWe      = (e == int'(VECS[v].wEdge)) ? VECS[v].we : 4'h0;
        userData    = VECS[v].wd;
        replDisturb = (e == int'(VECS[v].dEdge));
        tick();
        startReq = 0; userWe = '0; replDisturb = 0;
        if (done) begin
          cycles = e + 1;
          break;
        end
      end
      // R10 / R11 / R6 latency
      chk(VECS[v].comb ? "R11 latency" : (VECS[v].dEdge != 15 ? "R6 latency" : "R10 latency"),
          cycles, {28'b0, VECS[v].cyc});
      // R4 / R5 / R9 / R11 final contents
      chk("R4 R5 R9 R11 replQ", replQ, VECS[v].expR);
      chk("R9 origQ", origQ, VECS[v].expO);
      chk("R8 sysOut after switch", sysOut, VECS[v].expR);
      chk("R8 outSel after switch", {31'b0, outSel}, 32'h1);
    end

    // Directed: withheld acknowledges
    doReset();
    startReq = 1; tick(); startReq = 0;
    chk("R2 cfgReq raised", {31'b0, cfgReq}, 32'h1);
    userWe = 4'hF; userData = 32'h11111111; tick(); userWe = '0;
    chk("R2 cfgReq held without ack", {31'b0, cfgReq}, 32'h1);
    chk("R3 replica untouched before transfer", replQ, 32'h0);
    chk("R3 original written", origQ, 32'h11111111);
    cfgAck = 1; tick(); cfgAck = 0;
    chk("R2 cfgReq dropped after ack", {31'b0, cfgReq}, 32'h0);
    tick();
    chk("R4 replica copied", replQ, 32'h11111111);
    tick();
    chk("R7 no link during parallel cycle", {31'b0, linkReq}, 32'h0);
    tick();
    chk("R7 linkReq after parallel cycle", {31'b0, linkReq}, 32'h1);
    tick();
    chk("R8 outSel waits for linkAck", {31'b0, outSel}, 32'h0);
    chk("R8 sysOut from original", sysOut, origQ);
    linkAck = 1; tick(); linkAck = 0;
    chk("R8 outSel on ack", {31'b0, outSel}, 32'h1);
    chk("R10 done not yet", {31'b0, done}, 32'h0);
    tick();
    chk("R10 done one cycle after release", {31'b0, done}, 32'h1);
    userWe = 4'hF; userData = 32'h22222222; tick(); userWe = '0;
    chk("R9 original frozen", origQ, 32'h11111111);
    chk("R9 replica still written", replQ, 32'h22222222);
    chk("R8 sysOut follows replica", sysOut, 32'h22222222);
    startReq = 1; tick(); startReq = 0; tick();
    chk("R10 done sticky after extra start", {31'b0, done}, 32'h1);
    chk("R10 outSel kept after extra start", {31'b0, outSel}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule